// File: doc/BRIEF.md
# Hook supervision and first-digit call barring

This block sits between a telephone keypad scanner and the dialing engines. It watches the hook switch and a handsfree push input, and from them it works out when the set may dial. It also decides which key events reach the dialing engines. The hook input is synchronised. Going off-hook is seen at once, while going back on-hook must persist for a debounce window before it counts. Each low pulse on the handsfree input flips a handsfree state, and the set may dial whenever it is off-hook or handsfree is on.

A two-bit barring select picks one of three modes: free dialing, barring of 0 only, or barring of both 0 and 9. Either barring mode also places the block in lock mode. In lock mode the on-hook debounce is shortened, the line hold output is pulled low for a hold window after going off-hook, and keys are refused until that window ends. The window is shaped differently on the first off-hook after power-up. When the first key accepted in a call is a barred digit, that key and every later key are swallowed until the set goes back on-hook or is reset. All timing counts a one-millisecond tick supplied from outside.

Top module: `hook_bar_ctrl`

## Requirements
- R1: With `hook_n` high (after debounce) and handsfree off, `chip_en` is 0 and key strobes produce no `key_out_vld`. Driving `hook_n` low raises `chip_en` within four clock cycles.
- R2: Going on-hook takes effect only after `hook_n` has stayed high for 150 ticks in free mode or 20 ticks in lock mode. A high spell shorter than that leaves `chip_en` at 1.
- R3: Lock mode is `bar_sel` = 2'b01 or 2'b10. In lock mode `line_hold_n` is 0 for 300 ticks after going off-hook and 1 afterwards. In free mode (`bar_sel` = 2'b00 or 2'b11) it stays 1.
- R4: In lock mode a key strobe during the 300-tick off-hook window is dropped, and a key after the window is accepted. In free mode a key is accepted at once.
- R5: After a `por_flag` pulse, the first lock-mode off-hook drives `line_hold_n` 1 for 100 ticks and then 0. It stays 0 past 300 ticks until the first key is accepted, and returns to 1 two cycles later.
- R6: Key code 4'd0 is barred when `bar_sel` is 2'b01 or 2'b10. Key code 4'd9 is barred only when `bar_sel` is 2'b01. No code is barred when `bar_sel` is 2'b00 or 2'b11.
- R7: If the first accepted key of a call is barred, it gives no output, and every later key of that call gives no output.
- R8: Each high-to-low transition of `hf_n` flips `hf_out` once. `chip_en` is 1 whenever off-hook or `hf_out` is 1.
- R9: Completing the on-hook debounce clears `hf_out` and the barring latch, even when a handsfree edge lands in the same cycle.
- R10: An accepted key strobe gives a one-cycle `key_out_vld` one clock later, with `key_out_code` equal to the strobed code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1ms | input | 1 | One-cycle pulse each millisecond |
| hook_n | input | 1 | Hook switch, 1 = on-hook, 0 = off-hook |
| hf_n | input | 1 | Handsfree push input, active-low pulse |
| bar_sel | input | 2 | Barring mode: 00/11 free, 01 bar 0 and 9, 10 bar 0 |
| por_flag | input | 1 | Pulse marking that power has just come up |
| key_vld | input | 1 | Key event strobe |
| key_code | input | 4 | Key code (digits 0 to 9 as values) |
| key_out_vld | output | 1 | Filtered key strobe |
| key_out_code | output | 4 | Code of the filtered key |
| chip_en | output | 1 | Dialing enabled |
| hf_out | output | 1 | Handsfree state |
| line_hold_n | output | 1 | Line hold output, low while held |

## Verification
The completion of the on-hook debounce and a handsfree toggle edge can both arrive in the same clock cycle. One of them clears the handsfree state and the other flips it. The bench stops the free-running tick and places ticks by hand. It puts the last debounce tick in exactly the cycle where the synchronised handsfree fall is seen, with handsfree off beforehand. The check requires `hf_out` to stay 0 and `chip_en` to drop, so the clear must win over the toggle.

// File: rtl/hk_pkg.sv
package hk_pkg;

   typedef enum logic [1:0] {
      BAR_OFF       = 2'b00,
      BAR_ZERO_NINE = 2'b01,
      BAR_ZERO      = 2'b10,
      BAR_OFF_ALT   = 2'b11
   } bar_mode_e;

   function automatic logic lock_active(input bar_mode_e m);
      return (m == BAR_ZERO_NINE) || (m == BAR_ZERO);
   endfunction

endpackage

// File: rtl/hk_sync_edge.sv
module hk_sync_edge #(
   parameter int unsigned STAGES = 2,
   parameter bit          IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic fall
);

   logic [STAGES-1:0] sh_q;
   logic              last_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= IDLE;
            else        sh_q <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= {STAGES{IDLE}};
            else        sh_q <= {sh_q[STAGES-2:0], din};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= IDLE;
      else        last_q <= sh_q[STAGES-1];
   end

   assign level = sh_q[STAGES-1];
   assign fall  = last_q & ~sh_q[STAGES-1];

endmodule

// File: rtl/hk_hook_debounce.sv
module hk_hook_debounce #(
   parameter int unsigned NORM_MS = 150,
   parameter int unsigned LOCK_MS = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic onhook_lvl,
   input  logic lock,
   output logic offh,
   output logic onhook_evt
);

   localparam int unsigned MAX_MS = (NORM_MS > LOCK_MS) ? NORM_MS : LOCK_MS;
   localparam int unsigned CW     = $clog2(MAX_MS + 1);
   localparam logic [CW-1:0] NORM_LIM = CW'(NORM_MS - 1);
   localparam logic [CW-1:0] LOCK_LIM = CW'(LOCK_MS - 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;
   logic          offh_q;

   assign limit      = lock ? LOCK_LIM : NORM_LIM;
   assign onhook_evt = offh_q & onhook_lvl & tick & (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         offh_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         if (onhook_evt)       offh_q <= 1'b0;
         else if (!onhook_lvl) offh_q <= 1'b1;

         if (!onhook_lvl || !offh_q || onhook_evt) cnt_q <= '0;
         else if (tick && (cnt_q < limit))         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign offh = offh_q;

endmodule

// File: rtl/hk_hold_timer.sv
module hk_hold_timer #(
   parameter int unsigned HOLD_MS     = 300,
   parameter int unsigned POR_HIGH_MS = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic offh,
   input  logic lock,
   input  logic por_first,
   output logic hold_run,
   output logic line_hold_n
);

   localparam int unsigned HW = $clog2(HOLD_MS + 1);
   localparam logic [HW-1:0] HOLD_L = HW'(HOLD_MS);
   localparam logic [HW-1:0] HIGH_L = HW'(POR_HIGH_MS);

   logic [HW-1:0] cnt_q;
   logic          line_q;
   logic          early;
   logic          line_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (!offh)                    cnt_q <= '0;
      else if (tick && (cnt_q < HOLD_L)) cnt_q <= cnt_q + 1'b1;
   end

   assign hold_run = offh & (cnt_q < HOLD_L);
   assign early    = por_first & (cnt_q < HIGH_L);
   assign line_low = lock & offh & (hold_run ? ~early : por_first);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b1;
      else        line_q <= ~line_low;
   end

   assign line_hold_n = line_q;

endmodule

// File: rtl/hk_key_gate.sv
module hk_key_gate
   import hk_pkg::*;
#(
   parameter int unsigned KEY_W       = 4,
   parameter int unsigned ZERO_CODE   = 0,
   parameter int unsigned NINE_CODE   = 9,
   parameter bit          NINE_BAR_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_vld,
   input  logic [KEY_W-1:0] key_code,
   input  logic             chip_en,
   input  logic             lock,
   input  logic             hold_run,
   input  bar_mode_e        bar_mode,
   input  logic             onhook_evt,
   input  logic             por_flag,
   output logic             key_out_vld,
   output logic [KEY_W-1:0] key_out_code,
   output logic             barred,
   output logic             por_first
);

   logic is_zero, is_nine, hit;
   logic take, reject_first, pass;
   logic first_q, barred_q, por_q, vld_q;
   logic [KEY_W-1:0] code_q;

   assign is_zero = (key_code == KEY_W'(ZERO_CODE));

   generate
      if (NINE_BAR_EN) begin : g_nine
         assign is_nine = (key_code == KEY_W'(NINE_CODE));
      end else begin : g_no_nine
         assign is_nine = 1'b0;
      end
   endgenerate

   always_comb begin
      case (bar_mode)
         BAR_ZERO_NINE: hit = is_zero | is_nine;
         BAR_ZERO:      hit = is_zero;
         default:       hit = 1'b0;
      endcase
   end

   assign take         = key_vld & chip_en & ~barred_q & ~(lock & hold_run);
   assign reject_first = take & first_q & hit;
   assign pass         = take & ~reject_first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q    <= 1'b0;
         code_q   <= '0;
         first_q  <= 1'b1;
         barred_q <= 1'b0;
         por_q    <= 1'b0;
      end else begin
         vld_q <= pass;
         if (pass) code_q <= key_code;

         if (onhook_evt) begin
            first_q  <= 1'b1;
            barred_q <= 1'b0;
         end else if (reject_first) begin
            first_q  <= 1'b0;
            barred_q <= 1'b1;
         end else if (pass) begin
            first_q  <= 1'b0;
         end

         if (por_flag)                por_q <= 1'b1;
         else if (onhook_evt || pass) por_q <= 1'b0;
      end
   end

   assign key_out_vld  = vld_q;
   assign key_out_code = code_q;
   assign barred       = barred_q;
   assign por_first    = por_q;

endmodule

// File: rtl/hook_bar_ctrl.sv
module hook_bar_ctrl
   import hk_pkg::*;
#(
   parameter int unsigned KEY_W       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DEB_NORM_MS = 150,
   parameter int unsigned DEB_LOCK_MS = 20,
   parameter int unsigned HOLD_MS     = 300,
   parameter int unsigned POR_HIGH_MS = 100,
   parameter int unsigned ZERO_CODE   = 0,
   parameter int unsigned NINE_CODE   = 9,
   parameter bit          NINE_BAR_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_1ms,
   input  logic             hook_n,
   input  logic             hf_n,
   input  logic [1:0]       bar_sel,
   input  logic             por_flag,
   input  logic             key_vld,
   input  logic [KEY_W-1:0] key_code,
   output logic             key_out_vld,
   output logic [KEY_W-1:0] key_out_code,
   output logic             chip_en,
   output logic             hf_out,
   output logic             line_hold_n
);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (POR_HIGH_MS >= HOLD_MS) begin : g_bad_por
         $error("POR_HIGH_MS must be below HOLD_MS");
      end
      if (DEB_LOCK_MS < 1 || DEB_NORM_MS < 1) begin : g_bad_deb
         $error("debounce windows must be at least one tick");
      end
      if (ZERO_CODE >= (1 << KEY_W) || NINE_CODE >= (1 << KEY_W)) begin : g_bad_code
         $error("digit codes must fit KEY_W");
      end
   endgenerate

   bar_mode_e bar_mode;
   logic      lock_w;
   logic      hook_lvl_w, hook_fall_w;
   logic      hf_lvl_w, hf_fall_w;
   logic      offh_w, onhook_evt_w;
   logic      hold_run_w, por_first_w, barred_w;
   logic      hf_q;

   assign bar_mode = bar_mode_e'(bar_sel);
   assign lock_w   = lock_active(bar_mode);

   hk_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) i_hook_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (hook_n),
      .level (hook_lvl_w),
      .fall  (hook_fall_w)
   );

   hk_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) i_hf_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (hf_n),
      .level (hf_lvl_w),
      .fall  (hf_fall_w)
   );

   hk_hook_debounce #(.NORM_MS(DEB_NORM_MS), .LOCK_MS(DEB_LOCK_MS)) i_deb (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick_1ms),
      .onhook_lvl (hook_lvl_w),
      .lock       (lock_w),
      .offh       (offh_w),
      .onhook_evt (onhook_evt_w)
   );

   hk_hold_timer #(.HOLD_MS(HOLD_MS), .POR_HIGH_MS(POR_HIGH_MS)) i_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick_1ms),
      .offh        (offh_w),
      .lock        (lock_w),
      .por_first   (por_first_w),
      .hold_run    (hold_run_w),
      .line_hold_n (line_hold_n)
   );

   // clearing on the on-hook event outranks a same-cycle toggle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            hf_q <= 1'b0;
      else if (onhook_evt_w) hf_q <= 1'b0;
      else if (hf_fall_w)    hf_q <= ~hf_q;
   end

   assign hf_out  = hf_q;
   assign chip_en = offh_w | hf_q;

   hk_key_gate #(
      .KEY_W       (KEY_W),
      .ZERO_CODE   (ZERO_CODE),
      .NINE_CODE   (NINE_CODE),
      .NINE_BAR_EN (NINE_BAR_EN)
   ) i_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .key_vld      (key_vld),
      .key_code     (key_code),
      .chip_en      (chip_en),
      .lock         (lock_w),
      .hold_run     (hold_run_w),
      .bar_mode     (bar_mode),
      .onhook_evt   (onhook_evt_w),
      .por_flag     (por_flag),
      .key_out_vld  (key_out_vld),
      .key_out_code (key_out_code),
      .barred       (barred_w),
      .por_first    (por_first_w)
   );

endmodule

// File: rtl/hk_ctrl_checker.sv
module hk_ctrl_checker (
   input logic clk,
   input logic rst_n,
   input logic key_vld,
   input logic key_out_vld,
   input logic chip_en,
   input logic hf_out,
   input logic line_hold_n,
   input logic lock,
   input logic hold_run,
   input logic hf_fall,
   input logic offh,
   input logic barred
);

   // R10: a filtered strobe needs an enabled strobe one cycle before
   p_out_follows_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      key_out_vld |-> ($past(key_vld) && $past(chip_en)));

   // R4: no key passes while the lock-mode hold window runs
   p_window_blocks_keys_r4: assert property (@(posedge clk) disable iff (!rst_n)
      key_out_vld |-> !$past(lock && hold_run));

   // R8: handsfree only turns on after a synchronised falling edge
   p_hf_rise_needs_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hf_out) |-> $past(hf_fall));

   // R9: leaving off-hook leaves handsfree and barring cleared
   p_onhook_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(offh) |-> (!hf_out && !barred));

   // R7: a barred call emits nothing
   p_barred_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      barred |-> !key_out_vld);

   // R3: the line is only held in lock mode while off-hook
   p_line_only_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !line_hold_n |-> $past(lock && offh));

endmodule

bind hook_bar_ctrl hk_ctrl_checker i_hk_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .key_vld     (key_vld),
   .key_out_vld (key_out_vld),
   .chip_en     (chip_en),
   .hf_out      (hf_out),
   .line_hold_n (line_hold_n),
   .lock        (lock_w),
   .hold_run    (hold_run_w),
   .hf_fall     (hf_fall_w),
   .offh        (offh_w),
   .barred      (barred_w)
);

// File: tb/test_hook_bar_ctrl.sv
module test_hook_bar_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;
   localparam int NVEC       = 10;

   // vector: {bar_sel[1:0], code[3:0], expect_pass}
   localparam logic [6:0] VEC [NVEC] = '{
      {2'b00, 4'd0, 1'b1},
      {2'b00, 4'd9, 1'b1},
      {2'b01, 4'd0, 1'b0},
      {2'b01, 4'd9, 1'b0},
      {2'b01, 4'd5, 1'b1},
      {2'b10, 4'd0, 1'b0},
      {2'b10, 4'd9, 1'b1},
      {2'b11, 4'd0, 1'b1},
      {2'b10, 4'd3, 1'b1},
      {2'b01, 4'd1, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_auto = 1'b0, tick_man = 1'b0, tick_1ms;
   logic hook_n = 1'b1, hf_n = 1'b1, por_flag = 1'b0, key_vld = 1'b0;
   logic [1:0] bar_sel = 2'b00;
   logic [3:0] key_code = 4'd0;
   logic key_out_vld, chip_en, hf_out, line_hold_n;
   logic [3:0] key_out_code;
   logic auto_en = 1'b1;
   logic done = 1'b0;
   int tests = 0, fails = 0;

   assign tick_1ms = tick_auto | tick_man;

   always #(CLK_PERIOD/2) clk = ~clk;

   hook_bar_ctrl i_hook_bar_ctrl (
      .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .hook_n(hook_n),
      .hf_n(hf_n), .bar_sel(bar_sel), .por_flag(por_flag),
      .key_vld(key_vld), .key_code(key_code),
      .key_out_vld(key_out_vld), .key_out_code(key_out_code),
      .chip_en(chip_en), .hf_out(hf_out), .line_hold_n(line_hold_n)
   );

   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         ph = (ph + 1) % TICK_DIV;
         tick_auto = auto_en && (ph == 0);
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_ms(input int n);
      step(n * TICK_DIV);
   endtask

   task automatic press(input logic [3:0] c, output logic v, output logic [3:0] oc);
      key_vld = 1'b1; key_code = c;
      step(1);
      v = key_out_vld; oc = key_out_code;
      key_vld = 1'b0;
   endtask

   task automatic hf_pulse();
      hf_n = 1'b0; step(4);
      hf_n = 1'b1; step(4);
   endtask

   initial begin
      logic v;
      logic [3:0] oc;
      step(3);
      rst_n = 1'b1;
      step(2);
      // R1 reset state
      chk("R1 reset chip_en", chip_en, 0);
      chk("R1 reset hf_out", hf_out, 0);
      chk("R3 reset line", line_hold_n, 1);
      chk("R10 reset key_out_vld", key_out_vld, 0);
      press(4'd5, v, oc);
      chk("R1 key ignored on-hook", v, 0);

      // R5 first off-hook after power-up, lock mode
      por_flag = 1'b1; step(1); por_flag = 1'b0;
      bar_sel = 2'b10; hook_n = 1'b0; step(4);
      chk("R1 off-hook enables", chip_en, 1);
      wait_ms(50);  chk("R5 line high early", line_hold_n, 1);
      wait_ms(100); chk("R5 line low mid", line_hold_n, 0);
      wait_ms(170); chk("R5 line low past window", line_hold_n, 0);
      press(4'd5, v, oc);
      chk("R5 key accepted", v, 1);
      step(2);      chk("R5 line released", line_hold_n, 1);
      hook_n = 1'b1; wait_ms(30);

      // R3/R4 lock mode without power-up case
      bar_sel = 2'b01; hook_n = 1'b0; step(4);
      wait_ms(50); chk("R3 line held", line_hold_n, 0);
      press(4'd5, v, oc);
      chk("R4 key dropped in window", v, 0);
      wait_ms(240); chk("R3 line held at 290", line_hold_n, 0);
      wait_ms(20);  chk("R3 line released at 310", line_hold_n, 1);
      press(4'd5, v, oc);
      chk("R4 key after window", v, 1);
      chk("R10 code", oc, 5);
      hook_n = 1'b1; wait_ms(30);
      chk("R1 on-hook disables", chip_en, 0);

      // R3/R4 free mode
      bar_sel = 2'b00; hook_n = 1'b0; step(4);
      wait_ms(50); chk("R3 free line stays high", line_hold_n, 1);
      hook_n = 1'b0;
      hook_n = 1'b1; wait_ms(100); hook_n = 1'b0; step(4);
      chk("R2 short glitch ignored", chip_en, 1);
      hook_n = 1'b1; wait_ms(140);
      chk("R2 normal debounce not done", chip_en, 1);
      wait_ms(20);
      chk("R2 normal debounce done", chip_en, 0);
      press(4'd6, v, oc);
      chk("R1 key ignored after on-hook", v, 0);

      // R2 lock debounce
      bar_sel = 2'b10; hook_n = 1'b0; step(4);
      hook_n = 1'b1; wait_ms(15);
      chk("R2 lock debounce not done", chip_en, 1);
      wait_ms(10);
      chk("R2 lock debounce done", chip_en, 0);

      // vector table: R6 barring codes, R7 stickiness, R9 latch clear
      for (int i = 0; i < NVEC; i++) begin
         logic [6:0] e;
         e = VEC[i];
         bar_sel = e[6:5];
         hook_n = 1'b0;
         wait_ms(310);
         press(e[4:1], v, oc);
         chk($sformatf("R6 vec %0d first key", i), v, e[0]);
         if (e[0]) chk($sformatf("R10 vec %0d code", i), oc, e[4:1]);
         press(4'd5, v, oc);
         chk($sformatf("R7 vec %0d later key (R9 latch cleared)", i), v, e[0]);
         hook_n = 1'b1; wait_ms(170);
      end

      // R8 handsfree toggling on-hook
      bar_sel = 2'b00;
      hf_pulse();
      chk("R8 hf on", hf_out, 1);
      chk("R8 chip_en via hf", chip_en, 1);
      press(4'd7, v, oc);
      chk("R10 key in handsfree", v, 1);
      chk("R10 handsfree code", oc, 7);
      hf_pulse();
      chk("R8 hf off", hf_out, 0);
      chk("R8 chip_en off", chip_en, 0);

      // R9 on-hook clears handsfree
      hf_pulse();
      hook_n = 1'b0; step(4);
      hook_n = 1'b1; wait_ms(170);
      chk("R9 hf cleared", hf_out, 0);
      chk("R9 chip_en cleared", chip_en, 0);

      // R9 same-cycle clear and toggle, ticks placed by hand
      bar_sel = 2'b10; auto_en = 1'b0; step(2);
      hook_n = 1'b0; step(4);
      hook_n = 1'b1; step(4);
      repeat (19) begin
         tick_man = 1'b1; step(1);
         tick_man = 1'b0; step(1);
      end
      chk("R2 one tick short", chip_en, 1);
      hf_n = 1'b0;
      step(1);
      step(1);
      tick_man = 1'b1;
      step(1);
      tick_man = 1'b0;
      chk("R9 clear wins over toggle", hf_out, 0);
      chk("R9 chip_en drops", chip_en, 0);
      hf_n = 1'b1; step(4);
      chk("R8 no extra toggle", hf_out, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual running expected done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule